// File: doc/BRIEF.md
# Isochronous Receive Channel Filter

This block sits in the receive path of a serial-bus link controller. It decides, one header at a time, whether an incoming isochronous packet belongs to this node. A single 32-bit filter word, which the host writes and reads through a small register port, defines a set of receive slots. Each slot stores a tag value and a channel number. For every header the block compares the packet's tag and channel with each enabled slot. One clock later it reports whether the packet is accepted and which slot claimed it.

Each slot has its own enable input, so software can open or close a slot without rewriting its tag and channel. A separate snoop input makes the block accept every packet whatever its tag or channel, for bus monitoring. Slot count, tag width, channel width, word width and the register address are all parameters. The defaults give two slots of two tag bits and six channel bits in a 32-bit word at address 18h.

Top module: `iso_rx_filter`

## Requirements
- R1: After reset the filter word reads 0000_0000h at the register address, and acc_valid, acc_accept and acc_hit are all zero.
- R2: A write with host_wr high and host_addr equal to 18h stores the slot fields. Writes to any other address leave the stored word unchanged. Reads at any other address return zero.
- R3: The slot fields use these positions, with bit 0 of the serial-bus numbering as data line 31. Slot 1 tag is host_wdata[31:30] and slot 1 channel is host_wdata[29:24]. Slot 2 tag is host_wdata[23:22] and slot 2 channel is host_wdata[21:16].
- R4: host_wdata[15:0] is reserved. It is discarded on write and always reads back as zero.
- R5: A slot matches a header only when its enable is high and both hdr_tag and hdr_chan equal the slot's stored values. A match sets acc_accept and that slot's acc_hit bit. acc_hit bit 0 stands for slot 1 and bit 1 for slot 2.
- R6: A slot whose enable bit is low never matches, even when its tag and channel are equal to the header's. port_en bit 0 enables slot 1.
- R7: When several slots match the same header, only the lowest-numbered one is reported, so acc_hit has at most one bit set.
- R8: While snoop_en is high, every header is accepted (acc_accept = 1). acc_hit still shows the matching slot, or is zero if no slot matches.
- R9: The decision appears on the clock edge after the edge that samples hdr_valid, as a one-cycle acc_valid pulse. When acc_valid is low, acc_accept and acc_hit are zero.
- R10: A header presented in the same cycle as a filter write is judged against the word as it was before that write. The new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational on host_addr |
| port_en | input | 2 | Per-slot enable, bit 0 = slot 1 |
| snoop_en | input | 1 | Accept all packets |
| hdr_valid | input | 1 | Header strobe, one cycle per packet |
| hdr_tag | input | 2 | Packet tag field |
| hdr_chan | input | 6 | Packet channel number |
| acc_valid | output | 1 | Decision pulse |
| acc_accept | output | 1 | Packet accepted |
| acc_hit | output | 2 | One-hot matching slot, bit 0 = slot 1 |

## Verification
Two slots are loaded with different tags and channels. Headers are then sent that match each slot exactly, differ only in the tag, or differ only in the channel. This shows that both fields take part in the compare and that the slots are kept apart. The same headers are repeated with one enable dropped, with snoop set and no slot enabled, and with snoop set and a slot matching. These runs separate the effect of the enable from the effect of the override. Loading identical values into both slots exposes the priority, and a header sent in the same cycle as a rewrite of the word pins down when a new value takes effect.

// File: rtl/iso_filt_pkg.sv
package iso_filt_pkg;
   localparam int ISO_DATA_W   = 32;
   localparam int ISO_ADDR_W   = 8;
   localparam int ISO_TAG_W    = 2;
   localparam int ISO_CHAN_W   = 6;
   localparam int ISO_SLOTS    = 2;
   localparam logic [ISO_ADDR_W-1:0] ISO_REG_ADDR = 8'h18;

   // Most significant data line of slot p's byte (slot 0 leads the word).
   function automatic int slot_top(input int data_w, input int slot_w, input int p);
      return data_w - 1 - p * slot_w;
   endfunction
endpackage

// File: rtl/iso_filt_reg.sv
module iso_filt_reg
   import iso_filt_pkg::*;
#(
   parameter int DATA_W = ISO_DATA_W,
   parameter int ADDR_W = ISO_ADDR_W,
   parameter int FLD_W  = 16,
   parameter logic [ADDR_W-1:0] REG_ADDR = ISO_REG_ADDR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic [FLD_W-1:0]  fld_q
);
   logic sel;
   assign sel = (host_addr == REG_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              fld_q <= '0;
      else if (host_wr && sel) fld_q <= host_wdata[DATA_W-1 -: FLD_W];
   end

   always_comb begin
      host_rdata = '0;
      if (sel) host_rdata[DATA_W-1 -: FLD_W] = fld_q;
   end

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && sel) |=> (fld_q == $past(host_wdata[DATA_W-1 -: FLD_W]))); // R2
   AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !sel) |=> $stable(fld_q)); // R2
endmodule

// File: rtl/iso_filt_port_match.sv
module iso_filt_port_match #(
   parameter int TAG_W  = 2,
   parameter int CHAN_W = 6,
   localparam int SLOT_W = TAG_W + CHAN_W
) (
   input  logic              en,
   input  logic [SLOT_W-1:0] slot,
   input  logic [TAG_W-1:0]  tag,
   input  logic [CHAN_W-1:0] chan,
   output logic              hit
);
   logic tag_eq, chan_eq;
   assign tag_eq  = (slot[SLOT_W-1 -: TAG_W] == tag);
   assign chan_eq = (slot[CHAN_W-1:0] == chan);
   assign hit     = en && tag_eq && chan_eq;
endmodule

// File: rtl/iso_filt_decide.sv
module iso_filt_decide #(
   parameter int NUM_PORTS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 hdr_valid,
   input  logic                 snoop_en,
   input  logic [NUM_PORTS-1:0] raw_hit,
   output logic                 acc_valid,
   output logic                 acc_accept,
   output logic [NUM_PORTS-1:0] acc_hit
);
   logic [NUM_PORTS:0]   seen;
   logic [NUM_PORTS-1:0] pick;

   assign seen[0] = 1'b0;
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_prio
      assign pick[p]   = raw_hit[p] && !seen[p];
      assign seen[p+1] = seen[p] || raw_hit[p];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_valid  <= 1'b0;
         acc_accept <= 1'b0;
         acc_hit    <= '0;
      end else begin
         acc_valid  <= hdr_valid;
         acc_accept <= hdr_valid && (snoop_en || seen[NUM_PORTS]);
         acc_hit    <= hdr_valid ? pick : '0;
      end
   end

   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |=> acc_valid); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (!acc_accept && acc_hit == '0)); // R9
   AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(acc_hit)); // R7
   AST_LOW_SLOT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid && raw_hit[0]) |=> acc_hit[0]); // R7
   AST_SNOOP_TAKES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid && snoop_en) |=> acc_accept); // R8
   AST_HIT_IMPLIES_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_hit != '0) |-> acc_accept); // R5
endmodule

// File: rtl/iso_rx_filter.sv
module iso_rx_filter
   import iso_filt_pkg::*;
#(
   parameter int DATA_W    = ISO_DATA_W,
   parameter int ADDR_W    = ISO_ADDR_W,
   parameter int NUM_PORTS = ISO_SLOTS,
   parameter int TAG_W     = ISO_TAG_W,
   parameter int CHAN_W    = ISO_CHAN_W,
   parameter logic [ADDR_W-1:0] REG_ADDR = ISO_REG_ADDR
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_wr,
   input  logic [ADDR_W-1:0]    host_addr,
   input  logic [DATA_W-1:0]    host_wdata,
   output logic [DATA_W-1:0]    host_rdata,
   input  logic [NUM_PORTS-1:0] port_en,
   input  logic                 snoop_en,
   input  logic                 hdr_valid,
   input  logic [TAG_W-1:0]     hdr_tag,
   input  logic [CHAN_W-1:0]    hdr_chan,
   output logic                 acc_valid,
   output logic                 acc_accept,
   output logic [NUM_PORTS-1:0] acc_hit
);
   localparam int SLOT_W = TAG_W + CHAN_W;
   localparam int FLD_W  = NUM_PORTS * SLOT_W;

   if (NUM_PORTS < 1 || FLD_W > DATA_W) begin : g_bad_fit
      $error("iso_rx_filter: slots do not fit in the filter word");
   end
   if (TAG_W < 1 || CHAN_W < 1) begin : g_bad_width
      $error("iso_rx_filter: tag and channel widths must be positive");
   end

   logic [FLD_W-1:0]     fld_q;
   logic [NUM_PORTS-1:0] raw_hit;

   iso_filt_reg #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLD_W(FLD_W), .REG_ADDR(REG_ADDR)
   ) u_reg (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .fld_q(fld_q)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_slot
      localparam int TOP = slot_top(FLD_W, SLOT_W, p);
      iso_filt_port_match #(.TAG_W(TAG_W), .CHAN_W(CHAN_W)) u_match (
         .en(port_en[p]), .slot(fld_q[TOP -: SLOT_W]),
         .tag(hdr_tag), .chan(hdr_chan), .hit(raw_hit[p])
      );

      AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
         (hdr_valid && !port_en[p]) |=> !acc_hit[p]); // R6
   end

   iso_filt_decide #(.NUM_PORTS(NUM_PORTS)) u_decide (
      .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .snoop_en(snoop_en),
      .raw_hit(raw_hit), .acc_valid(acc_valid), .acc_accept(acc_accept),
      .acc_hit(acc_hit)
   );
endmodule

// File: tb/iso_rx_filter_tb.sv
module iso_rx_filter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [7:0]  host_addr = 8'h18;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic [1:0]  port_en = '0;
   logic        snoop_en = 1'b0;
   logic        hdr_valid = 1'b0;
   logic [1:0]  hdr_tag = '0;
   logic [5:0]  hdr_chan = '0;
   logic        acc_valid, acc_accept;
   logic [1:0]  acc_hit;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   iso_rx_filter u_dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .port_en(port_en),
      .snoop_en(snoop_en), .hdr_valid(hdr_valid), .hdr_tag(hdr_tag),
      .hdr_chan(hdr_chan), .acc_valid(acc_valid), .acc_accept(acc_accept),
      .acc_hit(acc_hit)
   );

   // {en[1:0], snoop, tag[1:0], chan[5:0], exp_accept, exp_hit[1:0]}
   // slot 1 = tag 2 / chan 05h, slot 2 = tag 1 / chan 3Fh
   localparam logic [13:0] VEC [9] = '{
      {2'b11, 1'b0, 2'd2, 6'h05, 1'b1, 2'b01},   // R5 slot 1 exact
      {2'b11, 1'b0, 2'd1, 6'h3F, 1'b1, 2'b10},   // R5 slot 2 exact
      {2'b11, 1'b0, 2'd0, 6'h05, 1'b0, 2'b00},   // R5 tag differs
      {2'b11, 1'b0, 2'd2, 6'h06, 1'b0, 2'b00},   // R5 channel differs
      {2'b10, 1'b0, 2'd2, 6'h05, 1'b0, 2'b00},   // R6 slot 1 off
      {2'b01, 1'b0, 2'd1, 6'h3F, 1'b0, 2'b00},   // R6 slot 2 off
      {2'b00, 1'b1, 2'd3, 6'h00, 1'b1, 2'b00},   // R8 snoop, no slot
      {2'b11, 1'b1, 2'd2, 6'h05, 1'b1, 2'b01},   // R8 snoop plus slot
      {2'b00, 1'b0, 2'd2, 6'h05, 1'b0, 2'b00}    // R6 all off
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic host_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0; host_addr = 8'h18;
   endtask

   task automatic read_check(input string req, input logic [7:0] a, input logic [31:0] exp);
      host_addr = a;
      #1 check(req, host_rdata, exp);
      host_addr = 8'h18;
   endtask

   // Drive one header at a negedge; decision is registered at the next posedge.
   task automatic send_hdr(input string req, input logic [1:0] en, input logic sn,
                           input logic [1:0] tg, input logic [5:0] ch,
                           input logic ex_acc, input logic [1:0] ex_hit);
      @(negedge clk);
      port_en = en; snoop_en = sn; hdr_tag = tg; hdr_chan = ch; hdr_valid = 1'b1;
      @(negedge clk);
      hdr_valid = 1'b0;
      check({req, " valid"}, {31'd0, acc_valid}, 32'd1);
      check({req, " accept"}, {31'd0, acc_accept}, {31'd0, ex_acc});
      check({req, " hit"}, {30'd0, acc_hit}, {30'd0, ex_hit});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      read_check("R1 reset word", 8'h18, 32'h0);
      check("R1 reset valid", {31'd0, acc_valid}, 32'd0);
      check("R1 reset hit/accept", {29'd0, acc_accept, acc_hit}, 32'd0);
      rst_n = 1'b1;

      // R3 R4 layout and reserved bits
      host_write(8'h18, 32'h857F_ABCD);
      read_check("R4 reserved read zero", 8'h18, 32'h857F_0000);
      // R2 foreign address
      host_write(8'h1C, 32'hFFFF_FFFF);
      read_check("R2 foreign write ignored", 8'h18, 32'h857F_0000);
      read_check("R2 foreign read zero", 8'h1C, 32'h0);

      // Table walk (R3 R5 R6 R8)
      foreach (VEC[i]) begin
         send_hdr($sformatf("R5/R6/R8 vec%0d", i), VEC[i][13:12], VEC[i][11],
                  VEC[i][10:9], VEC[i][8:3], VEC[i][2], VEC[i][1:0]);
      end

      // R9 idle cycle after decision
      @(negedge clk);
      check("R9 idle valid", {31'd0, acc_valid}, 32'd0);
      check("R9 idle quiet", {29'd0, acc_accept, acc_hit}, 32'd0);

      // R7 both slots hold tag 2 / chan 05h
      host_write(8'h18, 32'h8585_0000);
      send_hdr("R7 both match", 2'b11, 1'b0, 2'd2, 6'h05, 1'b1, 2'b01);
      send_hdr("R7 slot 2 alone", 2'b10, 1'b0, 2'd2, 6'h05, 1'b1, 2'b10);

      // R10 header in same cycle as rewrite sees the old word
      @(negedge clk);
      host_wr = 1'b1; host_addr = 8'h18; host_wdata = 32'h0185_0000;
      port_en = 2'b11; snoop_en = 1'b0; hdr_tag = 2'd0; hdr_chan = 6'h01; hdr_valid = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; hdr_valid = 1'b0;
      check("R10 old word used", {29'd0, acc_accept, acc_hit}, 32'd0);
      send_hdr("R10 new word used", 2'b11, 1'b0, 2'd0, 6'h01, 1'b1, 2'b01);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule